// File: doc/BRIEF.md
# Serial Frame Transmitter with Holding Register

This block turns a parallel byte into a ten-bit serial frame on a single output line. The rate is not derived from a divisor table: the host supplies the bit length directly as an 8-bit count of clock cycles. Each frame begins with a start bit at logic 1, continues with the eight data bits least significant first, and ends with a stop bit at logic 0. The line rests at 0 between frames, so the rising edge of the start bit marks the start of a frame.

The design is double-buffered. A one-cycle write strobe captures the byte into a holding register and drops the ready flag. If the shift register is empty, the byte moves into it on the next clock edge and the ready flag rises again. The host can therefore queue the following byte while the current frame is still being sent. A byte that is waiting when a frame's stop bit ends is sent immediately after it, with no idle cycle in between. If the host writes again while the holding register is still full, the new byte replaces the waiting one.

Top module: `txu_serializer`

## Requirements
- R1: While reset is asserted, and afterwards until a byte is written, hold_ready_o reads 1 and tx_o reads 0. Write strobes made during reset have no effect.
- R2: A write strobe drives hold_ready_o to 0 from the next cycle onwards. hold_ready_o returns to 1 after the clock edge at which the byte moves into the shift register. Without a strobe, hold_ready_o never falls.
- R3: Each frame on tx_o is ten bits long, sent in this order: a start bit of value 1, then data bit 0 up to data bit 7, then a stop bit of value 0.
- R4: Each bit of a frame stays on tx_o for exactly bit_period_i clock cycles. Values from 8 to 255 are supported.
- R5: If the transmitter is idle and a strobe is sampled at clock edge t, the start bit appears on tx_o after edge t+1.
- R6: If a byte is waiting in the holding register when a stop bit ends, that byte's start bit follows on the next cycle. No idle cycle is inserted, and the waiting byte reaches the line unchanged.
- R7: A strobe that arrives while the holding register is still full replaces the waiting byte. Only the last byte written is sent.
- R8: bit_period_i may change between frames, and every frame is timed with the value present while that frame is sent. The value must be held constant for the whole frame.
- R9: A strobe in the same cycle as a transfer into the shift register works as follows. The byte that was already held is sent. The new byte stays in the holding register, and hold_ready_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; deassertion must be synchronous to clk_i |
| wr_stb_i | input | 1 | One-cycle strobe that writes wr_data_i into the holding register |
| wr_data_i | input | DATA_W | Byte to send |
| bit_period_i | input | CNT_W | Number of clock cycles each serial bit lasts |
| tx_o | output | 1 | Serial line, 0 when idle |
| hold_ready_o | output | 1 | 1 when the holding register is free to take a byte |

## Verification
The bench drives its inputs on falling edges. A behavioural reference model steps on each rising edge, and the outputs are compared a quarter period after every rising edge, so every result is checked in the exact cycle it is due. In the model, a strobe sampled at edge t makes ready fall after edge t. If the line is idle, the start bit rises and ready returns after edge t+1. Each later bit boundary falls bit_period_i edges after the previous one, and a waiting byte's start bit falls exactly ten bit periods after the previous start. Directed phases cover the smallest and largest bit periods, the data bytes 0x00 and 0xFF, a byte queued during a frame, an overwrite of a waiting byte, and a strobe that coincides with a transfer.

// File: rtl/txu_pkg.sv
package txu_pkg;
  // Line levels of the frame
  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;
  localparam logic IDLE_LVL  = 1'b0;
  // Framing bits added around the data word
  localparam int unsigned FRAME_EXTRA = 2;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;
endpackage

// File: rtl/txu_holdreg.sv
module txu_holdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              data_en;

  // A write always wins over a transfer, so a byte written in the
  // transfer cycle stays held.
  always_comb begin
    full_d = full_q;
    if (wr_stb_i) begin
      full_d = 1'b1;
    end else if (take_i) begin
      full_d = 1'b0;
    end
  end

  assign data_en = wr_stb_i;
  assign data_d  = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/txu_rategen.sv
module txu_rategen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign last_val = period_i - CNT_W'(1);
  assign at_last  = (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !run_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i & at_last;
endmodule

// File: rtl/txu_shifter.sv
module txu_shifter
  import txu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              tick_i,
  output logic              tx_o,
  output logic              sending_o,
  output logic              done_o
);
  localparam int unsigned FRAME_W = DATA_W + FRAME_EXTRA;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  sh_state_e         state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               adv;

  assign adv    = (state_q == SH_SEND) & tick_i;
  assign done_o = adv & (idx_q == LAST_IDX);

  // Bit 0 of the shift register is the line; vacated bits fill with the
  // idle level so the line rests low after the stop bit.
  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    if (load_i) begin
      state_d = SH_SEND;
      sh_d    = {STOP_LVL, load_data_i, START_LVL};
      idx_d   = '0;
    end else if (adv) begin
      sh_d  = {IDLE_LVL, sh_q[FRAME_W-1:1]};
      idx_d = idx_q + IDX_W'(1);
      if (done_o) begin
        state_d = SH_IDLE;
        idx_d   = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      sh_q    <= {FRAME_W{IDLE_LVL}};
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
    end
  end

  assign tx_o      = sh_q[0];
  assign sending_o = (state_q == SH_SEND);
endmodule

// File: rtl/txu_serializer.sv
module txu_serializer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  bit_period_i,
  output logic              tx_o,
  output logic              hold_ready_o
);
  logic [DATA_W-1:0] held_data;
  logic              hold_full;
  logic              load;
  logic              tick;
  logic              sending;
  logic              done;

  // Transfer when the shifter is empty, or in the very cycle its last bit ends.
  assign load = hold_full & (~sending | done);

  txu_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb_i),
    .wr_data_i (wr_data_i),
    .take_i    (load),
    .data_o    (held_data),
    .full_o    (hold_full)
  );

  txu_rategen #(.CNT_W(CNT_W)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load),
    .run_i     (sending),
    .period_i  (bit_period_i),
    .tick_o    (tick)
  );

  txu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (held_data),
    .tick_i      (tick),
    .tx_o        (tx_o),
    .sending_o   (sending),
    .done_o      (done)
  );

  assign hold_ready_o = ~hold_full;
endmodule

// File: rtl/txu_serializer_chk.sv
module txu_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_stb_i,
  input logic tx_o,
  input logic hold_ready_o,
  input logic load,
  input logic tick,
  input logic sending,
  input logic done
);
  // R1
  idle_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sending |-> !tx_o);

  // R2
  wr_clears_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !hold_ready_o);

  // R2
  ready_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ready_o && !wr_stb_i |=> hold_ready_o);

  // R3
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> tx_o && sending);

  // R4
  line_edge_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_o) |-> $past(tick || load));

  // R6
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !hold_ready_o |=> tx_o && sending);
endmodule

bind txu_serializer txu_serializer_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_stb_i     (wr_stb_i),
  .tx_o         (tx_o),
  .hold_ready_o (hold_ready_o),
  .load         (load),
  .tick         (tick),
  .sending      (sending),
  .done         (done)
);

// File: tb/txu_serializer_tb_top.sv
module txu_serializer_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] period_r = 8'd8;
  logic       tx;
  logic       rdy;

  int    checks = 0;
  int    failures = 0;
  int    cyc_cnt = 0;
  string tag = "R1";

  // reference model state
  bit         m_active = 1'b0;
  int         m_idx = 0;
  int         m_cyc = 0;
  bit         m_hold_v = 1'b0;
  logic [7:0] m_hold = 8'h00;
  logic [7:0] m_frame = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  txu_serializer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_stb_i     (wr),
    .wr_data_i    (din),
    .bit_period_i (period_r),
    .tx_o         (tx),
    .hold_ready_o (rdy)
  );

  function automatic logic exp_tx();
    if (!m_active) return 1'b0;
    if (m_idx == 0) return 1'b1;       // start bit
    if (m_idx == 9) return 1'b0;       // stop bit
    return m_frame[m_idx-1];           // data, LSB first
  endfunction

  // Behavioural model: one step per rising clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 1'b0; m_idx = 0; m_cyc = 0; m_hold_v = 1'b0;
    end else begin
      if (m_active) begin
        m_cyc++;
        if (m_cyc == int'(period_r)) begin
          m_cyc = 0;
          m_idx++;
          if (m_idx == 10) m_active = 1'b0;
        end
      end
      if (m_hold_v && !m_active) begin
        m_active = 1'b1; m_idx = 0; m_cyc = 0;
        m_frame  = m_hold; m_hold_v = 1'b0;
      end
      if (wr) begin
        m_hold_v = 1'b1; m_hold = din;
      end
    end
  end

  // Compare every cycle, away from the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    checks++;
    if (tx !== exp_tx()) begin
      failures++;
      $display("FAIL %s tx_o actual=%0b expected=%0b at %0t", tag, tx, exp_tx(), $time);
    end
    checks++;
    if (rdy !== !m_hold_v) begin
      failures++;
      $display("FAIL %s hold_ready_o actual=%0b expected=%0b at %0t", tag, rdy, !m_hold_v, $time);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == WDOG) begin
      failures++;
      $display("FAIL %s watchdog actual=%0d expected<%0d", tag, cyc_cnt, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; din = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state, strobes during reset ignored
    tag = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr = (i % 2 == 0); din = 8'hC3;
      checks++;
      if (rdy !== 1'b1 || tx !== 1'b0) begin
        failures++;
        $display("FAIL R1 reset actual=%0b%0b expected=10", rdy, tx);
      end
    end
    @(negedge clk); wr = 1'b0; rst_n = 1'b1;
    idle_cycles(5);

    // R5 / R3: idle start, alternating pattern, minimum period
    tag = "R5"; period_r = 8'd8;
    send(8'hA5); idle_cycles(90);
    tag = "R3";
    send(8'h00); idle_cycles(90);
    send(8'hFF); idle_cycles(90);

    // R4 / R8: other periods, changed between frames
    tag = "R4"; period_r = 8'd13;
    send(8'h3C); idle_cycles(140);
    tag = "R8"; period_r = 8'd255;
    send(8'h96); idle_cycles(2560);
    period_r = 8'd9;
    send(8'h69); idle_cycles(100);

    // R2: ready falls after a strobe and rises after the transfer
    tag = "R2"; period_r = 8'd8;
    send(8'h5A); idle_cycles(3);
    send(8'h01); idle_cycles(180);

    // R6: byte queued during a frame follows with no gap
    tag = "R6";
    send(8'h11); idle_cycles(20);
    send(8'h22); idle_cycles(200);

    // R7: overwrite of a waiting byte
    tag = "R7";
    send(8'h33); idle_cycles(10);
    send(8'h44); idle_cycles(5);
    send(8'h55); idle_cycles(200);

    // R9: strobe in the transfer cycle
    tag = "R9";
    @(negedge clk); wr = 1'b1; din = 8'h66;
    @(negedge clk); din = 8'h77;
    @(negedge clk); wr = 1'b0;
    idle_cycles(200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule